// File: doc/BRIEF.md
# T1 Framing Bit Error Counter

This block watches the framing bits of a received T1 stream and counts each one that differs from the pattern expected at its position in the superframe. A framer that has already found superframe alignment presents each framing bit with a one-cycle strobe. With the strobe it gives the received bit value and the frame number, counted from 1, within the superframe. The block works out whether that frame carries a checked framing bit and which pattern value belongs there. Each mismatch adds one to an 8-bit counter.

Two framing formats are supported. In the extended superframe format, the framing bits of every fourth frame follow a 6-bit sequence. In the 12-frame format, the terminal framing bits in odd frames follow an alternating sequence. When an extra enable is set, the signalling framing bits in even frames are checked as well, and their errors go into the same counter. The counter stops at its maximum value. It holds while the framer reports loss of sync. A synchronous clear strobe returns it to zero.

Top module: `t1_fbit_err_cnt`

## Requirements
- R1: After reset `err_count` is 0.
- R2: With `esf_mode`=1, strobes in frames 4, 8, 12, 16, 20 and 24 are compared with the expected bits 0,0,1,0,1,1 in that frame order. A strobe with any other frame number has no effect on the count.
- R3: With `esf_mode`=0, strobes in odd frames 1, 3, 5, 7, 9 and 11 are compared with the expected bits 1,0,1,0,1,0 in that frame order. Frame numbers 0 and 13 to 31 have no effect on the count.
- R4: With `esf_mode`=0 and `fs_chk_en`=1, strobes in even frames 2, 4, 6, 8, 10 and 12 are compared with the expected bits 0,0,1,1,1,0 in that frame order. With `fs_chk_en`=0, even frames have no effect on the count.
- R5: Each strobe whose bit differs from the expected bit raises `err_count` by exactly one. The new value is visible after the clock edge that samples the strobe. A matching bit leaves the count unchanged.
- R6: At 255 the count stays at 255 when further errors arrive; it never wraps.
- R7: While `los` is 1, errors do not change the count.
- R8: `clr` sets the count to 0 on the next edge. This also holds when an error strobe arrives in the same cycle, at any count, and while `los` is 1.
- R9: Changing `esf_mode` or `fs_chk_en` does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fbit_vld | input | 1 | One-cycle framing bit strobe |
| fbit | input | 1 | Received framing bit value |
| frame_num | input | 5 | Frame number within the superframe, 1-based binary |
| esf_mode | input | 1 | 1 = extended 24-frame format, 0 = 12-frame format |
| fs_chk_en | input | 1 | Also check even-frame bits in the 12-frame format |
| los | input | 1 | Loss of sync; freezes the count |
| clr | input | 1 | Synchronous clear of the count |
| err_count | output | 8 | Current error count |

## Verification
The hardest state to reach from the ports is the top of the counter, together with the events that meet it there. Saturation needs 255 mismatching strobes, and a clear that coincides with an error only shows its priority when the count is non-zero. The stimulus therefore first sweeps every frame number and bit value in each mode configuration, building up a known count. It then drives a long run of forced mismatches past 255, fires further errors at the ceiling, and finally issues a clear in the same cycle as an error from the saturated value.

// File: rtl/t1_fbit_err_cnt.sv
module t1_fbit_err_cnt #(
  parameter int CNT_W = 8,
  parameter int FN_W = 5,
  parameter logic [5:0] ESF_SEQ = 6'b110100,
  parameter logic [5:0] FT_SEQ = 6'b010101,
  parameter logic [5:0] FS_SEQ = 6'b011100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fbit_vld,
  input  logic             fbit,
  input  logic [FN_W-1:0]  frame_num,
  input  logic             esf_mode,
  input  logic             fs_chk_en,
  input  logic             los,
  input  logic             clr,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [2:0] esf_pos, ft_pos, fs_pos;
  logic esf_slot, ft_slot, fs_slot, d4_range;
  logic exp_bit, checked, mismatch;

  assign esf_pos  = frame_num[4:2] - 3'd1;
  assign ft_pos   = frame_num[3:1];
  assign fs_pos   = frame_num[3:1] - 3'd1;

  assign esf_slot = (frame_num[1:0] == 2'b00) && (frame_num >= 5'd4) && (frame_num <= 5'd24);
  assign d4_range = (frame_num >= 5'd1) && (frame_num <= 5'd12);
  assign ft_slot  = d4_range && frame_num[0];
  assign fs_slot  = d4_range && !frame_num[0] && fs_chk_en;

  always_comb begin
    exp_bit = 1'b0;
    checked = 1'b0;
    if (esf_mode) begin
      checked = esf_slot;
      exp_bit = ESF_SEQ[esf_pos];
    end else if (ft_slot) begin
      checked = 1'b1;
      exp_bit = FT_SEQ[ft_pos];
    end else if (fs_slot) begin
      checked = 1'b1;
      exp_bit = FS_SEQ[fs_pos];
    end
  end

  assign mismatch = fbit_vld && checked && (fbit != exp_bit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr)
      cnt_q <= '0;
    else if (mismatch && !los && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  assign err_count = cnt_q;
endmodule

module t1_fbit_err_cnt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fbit_vld,
  input logic             los,
  input logic             clr,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> err_count == '0);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !clr) |=> err_count == CNT_MAX);

  // R7
  los_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !clr) |=> $stable(err_count));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fbit_vld && !clr) |=> $stable(err_count));

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));
endmodule

bind t1_fbit_err_cnt t1_fbit_err_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fbit_vld(fbit_vld), .los(los),
  .clr(clr), .err_count(err_count)
);

// File: tb/t1_fbit_err_cnt_tb.sv
module t1_fbit_err_cnt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fbit_vld = 1'b0, fbit = 1'b0, esf_mode = 1'b0, fs_chk_en = 1'b0;
  logic los = 1'b0, clr = 1'b0;
  logic [4:0] frame_num = '0;
  logic [7:0] err_count;
  int checks = 0, errors = 0, model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  t1_fbit_err_cnt u_dut (
    .clk(clk), .rst_n(rst_n), .fbit_vld(fbit_vld), .fbit(fbit),
    .frame_num(frame_num), .esf_mode(esf_mode), .fs_chk_en(fs_chk_en),
    .los(los), .clr(clr), .err_count(err_count)
  );

  function automatic bit is_err(bit esf, bit fsen, int f, bit b);
    bit esf_seq[6] = '{0, 0, 1, 0, 1, 1};
    bit ft_seq[6]  = '{1, 0, 1, 0, 1, 0};
    bit fs_seq[6]  = '{0, 0, 1, 1, 1, 0};
    if (esf) begin
      if (f >= 4 && f <= 24 && f % 4 == 0) return b != esf_seq[f / 4 - 1];
      return 0;
    end
    if (f < 1 || f > 12) return 0;
    if (f % 2 == 1) return b != ft_seq[(f - 1) / 2];
    if (fsen) return b != fs_seq[f / 2 - 1];
    return 0;
  endfunction

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(err_count) != exp) begin
      errors++;
      $display("FAIL %s: err_count=%0d expected=%0d", req, err_count, exp);
    end
  endtask

  task automatic strobe(input int f, input bit b, input bit c);
    fbit_vld = 1'b1; frame_num = 5'(f); fbit = b; clr = c;
    @(negedge clk);
    fbit_vld = 1'b0; clr = 1'b0;
  endtask

  task automatic wrong_bit(input int n);
    esf_mode = 1'b1;
    for (int i = 0; i < n; i++) strobe(12, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 0);

    // R2 R3 R4 R5: sweep all frame numbers, both bit values, all configurations
    for (int m = 0; m < 4; m++) begin
      esf_mode = m[1]; fs_chk_en = m[0];
      strobe(0, 1'b0, 1'b1);
      model = 0;
      check("R8 clear before sweep", 0);
      for (int f = 0; f < 32; f++) begin
        for (int b = 0; b < 2; b++) begin
          strobe(f, b[0], 1'b0);
          if (is_err(m[1], m[0], f, b[0])) model++;
          check(m[1] ? "R2 frame sweep" : (f % 2 == 1 ? "R3 frame sweep" : "R4 frame sweep"), model);
        end
      end
    end

    // R9: mode change keeps count
    esf_mode = 1'b0; fs_chk_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 mode change", model);

    // R7: los freezes count
    los = 1'b1;
    wrong_bit(5);
    check("R7 los freeze", model);
    los = 1'b0;
    wrong_bit(1);
    model++;
    check("R7 resume after los", model);

    // R6: saturation
    wrong_bit(300);
    check("R6 saturate", 255);
    wrong_bit(3);
    check("R6 hold at max", 255);

    // R8: clear wins over error, from saturation
    esf_mode = 1'b1;
    strobe(12, 1'b0, 1'b1);
    check("R8 clear beats error", 0);

    // R8: clear during los
    wrong_bit(4);
    check("R5 count after clear", 4);
    los = 1'b1;
    strobe(12, 1'b0, 1'b1);
    los = 1'b0;
    check("R8 clear during los", 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: err_count=%0d expected=finish", err_count);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule